// File: doc/BRIEF.md
# PHY Link Interface Sequencer

This block is the PHY end of a synchronous PHY-to-link interface. It runs on the system clock and has a 2-bit control bus and a 4-bit data bus. Both buses change direction between the PHY and the link controller. The block has four jobs:
- pass 16-bit status words to the link, two bits per cycle;
- forward received packet symbols to the link, led by a speed code;
- grant the bus to the link once arbitration is won;
- follow the link's hold, transmit and release codes while the link owns the bus.

Its inputs come from three places: the receive path (data-on, symbol valid, symbol, fast rate), a status queue (valid, word, pop), and the arbitration logic (a one-cycle won pulse). Every driven value and both output enables are registered. A change of bus owner therefore always leaves one undriven turnaround cycle, so the two sides never drive together.

Top module: `phy_link_seq`

## Requirements
- R1: During and right after reset, the block drives control 00 and data 0000 with both enables high, and `statTaken` is low.
- R2: A status transfer drives control 01 for 8 cycles. In cycle k (k = 0..7), data line 0 carries `statWord[15-2k]`, line 1 carries `statWord[14-2k]`, and lines 2 and 3 are 0. `statTaken` is high only during the 8th cycle.
- R3: A status transfer starts only after a cycle of driven idle. When `statValid` stays high across two words, at least one idle cycle (control 00) separates the two transfers.
- R4: `rxDataOn` during a status transfer makes the next cycle a receive cycle, and `statTaken` stays low. Once the bus is idle again, the whole word is resent from its first pair.
- R5: When `rxDataOn` is seen in idle, the next cycle drives control 10 with data 1111. This holds until the first valid symbol, which makes the next cycle carry the speed code. Each symbol then appears one cycle after the previous output, two cycles after it was presented. The cycle after the last symbol drives idle.
- R6: If `rxDataOn` falls before any symbol arrives, the next cycle drives idle.
- R7: The speed code is 0010 (only line 1 high) when `rxFast` is 1 and 0000 when it is 0. In a slow packet, lines 2 and 3 are 0 and lines 0 and 1 carry `rxSym[1:0]`. In a fast packet, all four lines carry the symbol.
- R8: An `arbWon` pulse in idle gives control 11 for exactly one cycle, then control 00 for one cycle, then both enables low.
- R9: While the link owns the bus, an idle code (00) before any hold (01) or transmit (10) is ignored. Once the link has sent hold or transmit, an idle sampled at an edge turns the enables back on one cycle later, driving control 00.
- R10: If the link sends hold right after transmit, the PHY drives idle for `GAP_CYC` cycles after it regains the bus, then grants again with the R8 sequence.
- R11: While the link owns the bus, the enables stay low whatever `rxDataOn`, `arbWon`, `statValid` or the reserved link code 11 do.
- R12: In idle, `rxDataOn` wins over `arbWon`, which wins over `statValid`. An `arbWon` during a status transfer cuts it off with a grant, and the word is resent later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxDataOn | input | 1 | Receive path sees data-on on the cable |
| rxSymValid | input | 1 | `rxSym` holds a packet symbol this cycle |
| rxSym | input | 4 | Received packet symbol |
| rxFast | input | 1 | Packet runs at the higher rate |
| statValid | input | 1 | Status queue holds a word |
| statWord | input | 16 | Status word at the head of the queue |
| statTaken | output | 1 | Pops the queue: last pair is on the bus |
| arbWon | input | 1 | One-cycle pulse: arbitration won |
| ctlIn | input | 2 | Control code sampled from the link |
| ctlOut | output | 2 | Control code driven by the PHY |
| ctlOe | output | 1 | Output enable for the control bus |
| dataOut | output | 4 | Data value driven by the PHY |
| dataOe | output | 1 | Output enable for the data bus |

## Verification
Every result reacts to an input one edge after it is sampled. There are three exceptions:
- a received symbol shows two edges after it is presented, because it waits one cycle behind the speed code;
- the re-enable after a link idle shows two edges later, because of the turnaround cycle;
- a re-grant follows `GAP_CYC` further idle cycles.

The bench drives inputs and samples outputs on the falling edge. It checks the output one falling edge later for ordinary one-edge results, and counts the extra edges itself for the three exceptions. It sweeps several status words, both rates with packet lengths of one to four symbols, and every cut-off and ownership sequence.

// File: rtl/phy_link_seq_pkg.sv
package phy_link_seq_pkg;
  localparam int IDX_W = 8;

  localparam logic [1:0] PCTL_IDLE   = 2'b00;
  localparam logic [1:0] PCTL_STATUS = 2'b01;
  localparam logic [1:0] PCTL_RECV   = 2'b10;
  localparam logic [1:0] PCTL_GRANT  = 2'b11;

  localparam logic [1:0] LCTL_IDLE = 2'b00;
  localparam logic [1:0] LCTL_HOLD = 2'b01;
  localparam logic [1:0] LCTL_XMIT = 2'b10;

  typedef enum logic [2:0] {
    DRV_IDLE, DRV_STAT, DRV_RXBEGIN, DRV_SPEED, DRV_SYM, DRV_GRANT, DRV_OFF
  } drvSel_e;

  typedef struct packed {
    drvSel_e          sel;
    logic [IDX_W-1:0] statIdx;
  } drvStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_STAT, ST_RXBEGIN, ST_RXDATA, ST_GRANT,
    ST_GIDLE, ST_LINK, ST_TURN, ST_REGAP
  } seqState_e;
endpackage

// File: rtl/phy_link_seq_ctrl.sv
module phy_link_seq_ctrl
  import phy_link_seq_pkg::*;
#(
  parameter int STAT_W  = 16,
  parameter int GAP_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxDataOn,
  input  logic       rxSymValid,
  input  logic       statValid,
  input  logic       arbWon,
  input  logic [1:0] ctlIn,
  output logic       statTaken,
  output drvStrobe_t strobe
);
  localparam int PAIRS = STAT_W / 2;
  localparam int CNT_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST_PAIR = CNT_W'(PAIRS - 1);
  localparam logic [GAP_W-1:0] GAP_LAST  = GAP_W'(GAP_CYC - 1);

  seqState_e        st, stNext;
  logic [CNT_W-1:0] statCnt, cntNext, idx;
  logic [GAP_W-1:0] gapCnt, gapNext;
  drvSel_e          sel;
  logic             holdValid, linkActive, prevTx, reGrant;

  always_comb begin
    stNext    = st;
    cntNext   = statCnt;
    gapNext   = gapCnt;
    sel       = DRV_IDLE;
    idx       = statCnt;
    statTaken = 1'b0;
    unique case (st)
      ST_IDLE, ST_STAT: begin
        if (rxDataOn) begin
          stNext = ST_RXBEGIN;
          sel    = DRV_RXBEGIN;
        end else if (arbWon) begin
          stNext = ST_GRANT;
          sel    = DRV_GRANT;
        end else if (st == ST_IDLE) begin
          if (statValid) begin
            stNext  = ST_STAT;
            sel     = DRV_STAT;
            idx     = '0;
            cntNext = '0;
          end
        end else if (statCnt == LAST_PAIR) begin
          stNext    = ST_IDLE;
          statTaken = 1'b1;
        end else begin
          sel     = DRV_STAT;
          idx     = statCnt + 1'b1;
          cntNext = statCnt + 1'b1;
        end
      end
      ST_RXBEGIN: begin
        if (!rxDataOn) begin
          stNext = ST_IDLE;
        end else if (rxSymValid) begin
          stNext = ST_RXDATA;
          sel    = DRV_SPEED;
        end else begin
          sel = DRV_RXBEGIN;
        end
      end
      ST_RXDATA: begin
        if (holdValid) sel = DRV_SYM;
        else           stNext = ST_IDLE;
      end
      ST_GRANT: stNext = ST_GIDLE;
      ST_GIDLE: begin
        stNext = ST_LINK;
        sel    = DRV_OFF;
      end
      ST_LINK: begin
        sel = DRV_OFF;
        if (ctlIn == LCTL_IDLE && linkActive) stNext = ST_TURN;
      end
      ST_TURN: begin
        stNext  = reGrant ? ST_REGAP : ST_IDLE;
        gapNext = '0;
      end
      ST_REGAP: begin
        if (rxDataOn) begin
          stNext = ST_RXBEGIN;
          sel    = DRV_RXBEGIN;
        end else if (gapCnt == GAP_LAST) begin
          stNext = ST_GRANT;
          sel    = DRV_GRANT;
        end else begin
          gapNext = gapCnt + 1'b1;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      statCnt    <= '0;
      gapCnt     <= '0;
      holdValid  <= 1'b0;
      linkActive <= 1'b0;
      prevTx     <= 1'b0;
      reGrant    <= 1'b0;
    end else begin
      st        <= stNext;
      statCnt   <= cntNext;
      gapCnt    <= gapNext;
      holdValid <= rxSymValid;
      if (st == ST_GIDLE) begin
        linkActive <= 1'b0;
        prevTx     <= 1'b0;
        reGrant    <= 1'b0;
      end else if (st == ST_LINK) begin
        if (ctlIn == LCTL_HOLD || ctlIn == LCTL_XMIT) linkActive <= 1'b1;
        if (ctlIn == LCTL_HOLD && prevTx) reGrant <= 1'b1;
        prevTx <= (ctlIn == LCTL_XMIT);
      end
    end
  end

  assign strobe.sel     = sel;
  assign strobe.statIdx = IDX_W'(idx);

  AST_DONE_LEAVES_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    statTaken |=> (st != ST_STAT)); // R3
endmodule

// File: rtl/phy_link_seq_dp.sv
module phy_link_seq_dp
  import phy_link_seq_pkg::*;
#(
  parameter int STAT_W = 16,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  drvStrobe_t        strobe,
  input  logic [STAT_W-1:0] statWord,
  input  logic [DATA_W-1:0] rxSym,
  input  logic              rxSymValid,
  input  logic              rxFast,
  output logic [1:0]        ctlOut,
  output logic              ctlOe,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  logic [DATA_W-1:0] symHold, dataNext;
  logic [STAT_W-1:0] statShift;
  logic [1:0]        ctlNext;
  logic              oeNext, fastQ;

  always_comb begin
    statShift = statWord << (2 * strobe.statIdx);
    ctlNext   = PCTL_IDLE;
    dataNext  = '0;
    oeNext    = 1'b1;
    unique case (strobe.sel)
      DRV_STAT: begin
        ctlNext     = PCTL_STATUS;
        dataNext[0] = statShift[STAT_W-1];
        dataNext[1] = statShift[STAT_W-2];
      end
      DRV_RXBEGIN: begin
        ctlNext  = PCTL_RECV;
        dataNext = '1;
      end
      DRV_SPEED: begin
        ctlNext     = PCTL_RECV;
        dataNext[1] = rxFast;
      end
      DRV_SYM: begin
        ctlNext = PCTL_RECV;
        if (fastQ) dataNext = symHold;
        else       dataNext[1:0] = symHold[1:0];
      end
      DRV_GRANT: ctlNext = PCTL_GRANT;
      DRV_OFF:   oeNext = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlOut  <= PCTL_IDLE;
      dataOut <= '0;
      ctlOe   <= 1'b1;
      dataOe  <= 1'b1;
      symHold <= '0;
      fastQ   <= 1'b0;
    end else begin
      ctlOut  <= ctlNext;
      dataOut <= dataNext;
      ctlOe   <= oeNext;
      dataOe  <= oeNext;
      if (rxSymValid) symHold <= rxSym;
      if (strobe.sel == DRV_SPEED) fastQ <= rxFast;
    end
  end

  AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (ctlOe && ctlOut == PCTL_GRANT) |=> (ctlOe && ctlOut == PCTL_IDLE)); // R8
  AST_RELEASE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctlOe) |-> ($past(ctlOut) == PCTL_IDLE)); // R8
  AST_RESUME_WITH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlOe) |-> (ctlOut == PCTL_IDLE)); // R9
  AST_STATUS_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (ctlOe && ctlOut == PCTL_STATUS && !($past(ctlOe) && $past(ctlOut) == PCTL_STATUS))
      |-> ($past(ctlOe) && $past(ctlOut) == PCTL_IDLE)); // R3
endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
  import phy_link_seq_pkg::*;
#(
  parameter int STAT_W  = 16,
  parameter int DATA_W  = 4,
  parameter int GAP_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxDataOn,
  input  logic              rxSymValid,
  input  logic [DATA_W-1:0] rxSym,
  input  logic              rxFast,
  input  logic              statValid,
  input  logic [STAT_W-1:0] statWord,
  output logic              statTaken,
  input  logic              arbWon,
  input  logic [1:0]        ctlIn,
  output logic [1:0]        ctlOut,
  output logic              ctlOe,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  drvStrobe_t strobe;

  phy_link_seq_ctrl #(.STAT_W(STAT_W), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxDataOn(rxDataOn), .rxSymValid(rxSymValid),
    .statValid(statValid), .arbWon(arbWon), .ctlIn(ctlIn),
    .statTaken(statTaken), .strobe(strobe)
  );

  phy_link_seq_dp #(.STAT_W(STAT_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statWord(statWord),
    .rxSym(rxSym), .rxSymValid(rxSymValid), .rxFast(rxFast),
    .ctlOut(ctlOut), .ctlOe(ctlOe), .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: tb/phy_link_seq_bench.sv
`timescale 1ns/1ps
module phy_link_seq_bench;
  localparam int GAP = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, rxDataOn, rxSymValid, rxFast, statValid, statTaken, arbWon;
  logic [3:0] rxSym, dataOut;
  logic [15:0] statWord;
  logic [1:0] ctlIn, ctlOut;
  logic ctlOe, dataOe;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  phy_link_seq u_phy_link_seq (
    .clk(clk), .rstN(rstN), .rxDataOn(rxDataOn), .rxSymValid(rxSymValid),
    .rxSym(rxSym), .rxFast(rxFast), .statValid(statValid), .statWord(statWord),
    .statTaken(statTaken), .arbWon(arbWon), .ctlIn(ctlIn), .ctlOut(ctlOut),
    .ctlOe(ctlOe), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expOut(string req, logic [1:0] c, logic [3:0] d, logic oe);
    logic [7:0] act, exp;
    act = {ctlOe, dataOe, ctlOut, dataOut};
    exp = {oe, oe, c, d};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {oeC,oeD,ctl,data} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic expTaken(string req, logic e);
    nChecks++;
    if (statTaken !== e) begin
      nFails++;
      $display("FAIL %s: statTaken actual %b expected %b", req, statTaken, e);
    end
  endtask

  // Eight pairs of w, then an idle cycle (R2, R3)
  task automatic statPairs(logic [15:0] w, bit keep);
    for (int k = 0; k < 8; k++) begin
      tick();
      expOut("R2", 2'b01, {2'b00, w[14-2*k], w[15-2*k]}, 1'b1);
      expTaken("R2", k == 7);
    end
    if (!keep) statValid = 1'b0;
    tick();
    expOut("R3", 2'b00, 4'h0, 1'b1);
  endtask

  task automatic runStatus(logic [15:0] w, bit keep);
    statValid = 1'b1;
    statWord = w;
    statPairs(w, keep);
  endtask

  function automatic logic [3:0] symOf(int j, int n);
    return 4'((j * 7 + n * 3 + 9) & 15);
  endfunction

  task automatic rxPacket(logic fast, int n);
    logic [3:0] mask;
    mask = fast ? 4'hF : 4'h3;
    rxDataOn = 1'b1;
    tick();
    expOut("R5", 2'b10, 4'hF, 1'b1);
    tick();
    expOut("R5", 2'b10, 4'hF, 1'b1);
    for (int j = 0; j < n; j++) begin
      rxSymValid = 1'b1;
      rxSym = symOf(j, n);
      rxFast = fast;
      tick();
      if (j == 0) expOut("R7", 2'b10, fast ? 4'b0010 : 4'b0000, 1'b1);
      else        expOut("R7", 2'b10, symOf(j - 1, n) & mask, 1'b1);
    end
    rxSymValid = 1'b0;
    rxDataOn = 1'b0;
    rxFast = 1'b0;
    tick();
    expOut("R5", 2'b10, symOf(n - 1, n) & mask, 1'b1);
    tick();
    expOut("R5", 2'b00, 4'h0, 1'b1);
  endtask

  // Grant sequence after an arbWon pulse (R8)
  task automatic grantSeq();
    arbWon = 1'b1;
    tick();
    expOut("R8", 2'b11, 4'h0, 1'b1);
    arbWon = 1'b0;
    tick();
    expOut("R8", 2'b00, 4'h0, 1'b1);
    tick();
    expOut("R8", 2'b00, 4'h0, 1'b0);
  endtask

  task automatic linkStep(logic [1:0] code, string req);
    ctlIn = code;
    tick();
    expOut(req, 2'b00, 4'h0, 1'b0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; rxDataOn = 1'b0; rxSymValid = 1'b0; rxFast = 1'b0; rxSym = '0;
    statValid = 1'b0; statWord = '0; arbWon = 1'b0; ctlIn = 2'b00;
    repeat (3) tick();
    expOut("R1", 2'b00, 4'h0, 1'b1);
    expTaken("R1", 1'b0);
    rstN = 1'b1;
    tick();
    expOut("R1", 2'b00, 4'h0, 1'b1);

    // R2 / R3: status sweep, back-to-back words separated by idle
    for (int i = 0; i < 6; i++) begin
      runStatus(16'((i * 16'h3A71) ^ 16'h5A0F), i < 5);
    end
    runStatus(16'hFFFF, 1'b1);
    runStatus(16'h0000, 1'b0);

    // R4 / R6: status cut by data-on, no packet, then resent whole
    statValid = 1'b1;
    statWord = 16'hC3A5;
    for (int k = 0; k < 3; k++) begin
      tick();
      expOut("R2", 2'b01, {2'b00, statWord[14-2*k], statWord[15-2*k]}, 1'b1);
    end
    rxDataOn = 1'b1;
    tick();
    expOut("R4", 2'b10, 4'hF, 1'b1);
    expTaken("R4", 1'b0);
    rxDataOn = 1'b0;
    tick();
    expOut("R6", 2'b00, 4'h0, 1'b1);
    statPairs(16'hC3A5, 1'b0);

    // R5 / R7: receive sweep over both rates and lengths
    for (int f = 0; f < 2; f++) begin
      for (int n = 1; n <= 4; n++) begin
        rxPacket(f[0], n);
      end
    end

    // R8 / R9 / R11: grant, link ownership, ignored inputs
    grantSeq();
    rxDataOn = 1'b1; arbWon = 1'b1; statValid = 1'b1; statWord = 16'h1234;
    linkStep(2'b00, "R11");
    linkStep(2'b00, "R9");
    rxDataOn = 1'b0; arbWon = 1'b0; statValid = 1'b0;
    linkStep(2'b01, "R9");
    linkStep(2'b11, "R11");
    linkStep(2'b10, "R9");
    linkStep(2'b10, "R9");
    linkStep(2'b00, "R9");
    tick();
    expOut("R9", 2'b00, 4'h0, 1'b1);
    tick();
    expOut("R9", 2'b00, 4'h0, 1'b1);

    // R10: hold after transmit asks for a re-grant after GAP idle cycles
    grantSeq();
    linkStep(2'b10, "R10");
    linkStep(2'b10, "R10");
    linkStep(2'b01, "R10");
    linkStep(2'b00, "R10");
    for (int g = 0; g < GAP; g++) begin
      tick();
      expOut("R10", 2'b00, 4'h0, 1'b1);
    end
    tick();
    expOut("R10", 2'b11, 4'h0, 1'b1);
    tick();
    expOut("R10", 2'b00, 4'h0, 1'b1);
    tick();
    expOut("R10", 2'b00, 4'h0, 1'b0);
    linkStep(2'b10, "R10");
    linkStep(2'b00, "R10");
    tick();
    expOut("R9", 2'b00, 4'h0, 1'b1);

    // R12: priority in idle, then a grant cuts a status transfer
    rxDataOn = 1'b1; arbWon = 1'b1; statValid = 1'b1; statWord = 16'h9E61;
    tick();
    expOut("R12", 2'b10, 4'hF, 1'b1);
    rxDataOn = 1'b0; arbWon = 1'b0; statValid = 1'b0;
    tick();
    expOut("R12", 2'b00, 4'h0, 1'b1);
    arbWon = 1'b1; statValid = 1'b1;
    tick();
    expOut("R12", 2'b11, 4'h0, 1'b1);
    arbWon = 1'b0;
    tick();
    expOut("R12", 2'b00, 4'h0, 1'b1);
    tick();
    expOut("R12", 2'b00, 4'h0, 1'b0);
    linkStep(2'b10, "R12");
    linkStep(2'b00, "R12");
    tick();
    expOut("R12", 2'b00, 4'h0, 1'b1);
    tick();
    expOut("R12", 2'b01, {2'b00, statWord[14], statWord[15]}, 1'b1);
    tick();
    expOut("R12", 2'b01, {2'b00, statWord[12], statWord[13]}, 1'b1);
    arbWon = 1'b1;
    tick();
    expOut("R12", 2'b11, 4'h0, 1'b1);
    expTaken("R12", 1'b0);
    arbWon = 1'b0;
    tick();
    expOut("R12", 2'b00, 4'h0, 1'b1);
    tick();
    expOut("R12", 2'b00, 4'h0, 1'b0);
    linkStep(2'b01, "R12");
    linkStep(2'b00, "R12");
    tick();
    expOut("R12", 2'b00, 4'h0, 1'b1);
    statPairs(16'h9E61, 1'b0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule